// File: doc/BRIEF.md
# Bridge Secondary Error Status Register

This block holds the 16-bit error status word for the downstream (link) side of a virtual PCI-to-PCI bridge. Link logic sends it single-cycle strobes. A strobe marks one of these events: a poisoned TLP arrived, a fatal or non-fatal error message arrived, a completion came back with Unsupported Request or Completer Abort status, or a read-data completion arrived poisoned. Each strobe sets its own sticky bit. The bit keeps that value until software writes a 1 to it through the configuration port.

Completion-status strobes count only when a companion flag shows that the request came from the bridge itself. The poisoned read-completion bit also needs the parity error response enable from the bridge control register. The general poisoned-TLP bit does not. All other bits of the word read zero and ignore writes. If a clear and a new event hit the same bit in the same cycle, the event wins, so no error is lost.

Top module: `sec_err_status`

## Requirements
- R1: After a synchronous active-low reset the word reads 0000h.
- R2: Bit 15 sets on a poisoned-TLP strobe, whatever the parity error response enable is.
- R3: Bit 14 sets on a received fatal or non-fatal error message strobe.
- R4: Bit 13 sets on an Unsupported Request completion strobe only while the self-initiated flag is 1. With the flag at 0 the strobe leaves the word unchanged.
- R5: Bit 12 sets on a Completer Abort completion strobe only while the self-initiated flag is 1. With the flag at 0 the strobe leaves the word unchanged.
- R6: Bit 8 sets on a poisoned read-completion strobe only while the parity error response enable is 1.
- R7: A write with a 1 in bit 15, 14, 13, 12 or 8 clears that bit at the next clock edge. A write with a 0 in that bit leaves it unchanged.
- R8: A write affects only enabled bytes: byte enable bit 0 covers bits 7:0 and byte enable bit 1 covers bits 15:8. A write whose byte address, with bit 0 ignored, differs from 1Eh has no effect.
- R9: When a set event and a write-1 clear reach the same bit in one cycle, the bit ends at 1.
- R10: Bits 11:9 and 7:0 always read 0 and ignore writes, even when every event strobe fires at once.
- R11: The read data equals the word while the read strobe is high and the address matches 1Eh. Otherwise the read data is 0000h.
- R12: A set bit stays set through repeated events of its kind, and a single write-1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_poison_rx | input | 1 | Poisoned TLP received strobe |
| ev_errmsg_rx | input | 1 | Fatal or non-fatal error message received strobe |
| ev_cpl_ur | input | 1 | Completion with Unsupported Request status strobe |
| ev_cpl_ca | input | 1 | Completion with Completer Abort status strobe |
| ev_cpl_self | input | 1 | Completion belongs to a bridge-initiated request |
| ev_rdcpl_poison | input | 1 | Poisoned read-data completion strobe |
| perr_resp_en | input | 1 | Parity error response enable |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_be | input | 2 | Byte enables |
| cfg_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data |

## Verification
A wrong bit in the stored word shows on rd_data one clock after the edge that produced it. Reading the register exposes the whole word at once. The bench reads it after every cycle. A lost event, a missed clear, a clear on a disabled byte or a bit that wrongly comes out of a read-only position is therefore reported within one cycle. Same-cycle set-and-clear races and the two gating conditions are forced in directed steps, because a random mix would rarely hit them.

// File: rtl/sec_err_pkg.sv
// Package: shared constants for the secondary error status register.
// Assumes a 16-bit word whose sticky bit positions are fixed, because
// software decodes them.
package sec_err_pkg;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int NBYTES   = WORD_W / BYTE_W;
    localparam int B_DPE    = 15;
    localparam int B_RSE    = 14;
    localparam int B_RMA    = 13;
    localparam int B_RTA    = 12;
    localparam int B_MDPE   = 8;
    localparam logic [WORD_W-1:0] STICKY_MASK =
        (16'h1 << B_DPE) | (16'h1 << B_RSE) | (16'h1 << B_RMA) |
        (16'h1 << B_RTA) | (16'h1 << B_MDPE);
endpackage

// File: rtl/sec_err_set_decode.sv
// Module: turns link event strobes into a per-bit set vector.
// Assumes the strobes are one cycle wide and already synchronous to clk.
module sec_err_set_decode
    import sec_err_pkg::*;
(
    input  logic              ev_poison_rx,
    input  logic              ev_errmsg_rx,
    input  logic              ev_cpl_ur,
    input  logic              ev_cpl_ca,
    input  logic              ev_cpl_self,
    input  logic              ev_rdcpl_poison,
    input  logic              perr_resp_en,
    output logic [WORD_W-1:0] set_vec
);
    // Qualify each strobe with its own condition and place it on its bit.
    always_comb begin
        set_vec          = '0;
        set_vec[B_DPE]   = ev_poison_rx;
        set_vec[B_RSE]   = ev_errmsg_rx;
        set_vec[B_RMA]   = ev_cpl_ur & ev_cpl_self;
        set_vec[B_RTA]   = ev_cpl_ca & ev_cpl_self;
        set_vec[B_MDPE]  = ev_rdcpl_poison & perr_resp_en;
    end
endmodule

// File: rtl/sec_err_clr_decode.sv
// Module: builds the write-1 clear vector from a configuration write.
// Assumes a byte address and ignores its bit 0, since the word is
// two bytes wide.
module sec_err_clr_decode
    import sec_err_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] REG_OFFSET = 12'h01E
) (
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [NBYTES-1:0] cfg_be,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              addr_hit,
    output logic [WORD_W-1:0] clr_vec
);
    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

    // Compare the word address, dropping the byte-select bit.
    always_comb addr_hit = (cfg_addr[ADDR_W-1:1] == OFFS[ADDR_W-1:1]);

    // Each enabled byte of a hitting write passes its ones as clears.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_comb clr_vec[b*BYTE_W +: BYTE_W] =
            (cfg_wr && addr_hit && cfg_be[b]) ? cfg_wdata[b*BYTE_W +: BYTE_W]
                                              : '0;
    end
endmodule

// File: rtl/sec_err_sticky_cell.sv
// Module: one sticky status bit with write-1 clear.
// Assumes that a set in the same cycle as a clear takes priority.
module sec_err_sticky_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Hold, set or clear the bit; set outranks clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q);
    a_r12_stays_set: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_i) |=> q);
endmodule

// File: rtl/sec_err_status.sv
// Module: secondary-side error status word of a virtual bridge.
// Collects qualified link error events into sticky bits, clears them on
// write-1 and returns the word on a matching read. Assumes one
// configuration access per cycle and a synchronous active-low reset.
module sec_err_status
    import sec_err_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] REG_OFFSET = 12'h01E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_poison_rx,
    input  logic              ev_errmsg_rx,
    input  logic              ev_cpl_ur,
    input  logic              ev_cpl_ca,
    input  logic              ev_cpl_self,
    input  logic              ev_rdcpl_poison,
    input  logic              perr_resp_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [NBYTES-1:0] cfg_be,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] clr_vec;
    logic [WORD_W-1:0] status;
    logic              addr_hit;

    sec_err_set_decode u_set (
        .ev_poison_rx    (ev_poison_rx),
        .ev_errmsg_rx    (ev_errmsg_rx),
        .ev_cpl_ur       (ev_cpl_ur),
        .ev_cpl_ca       (ev_cpl_ca),
        .ev_cpl_self     (ev_cpl_self),
        .ev_rdcpl_poison (ev_rdcpl_poison),
        .perr_resp_en    (perr_resp_en),
        .set_vec         (set_vec)
    );

    sec_err_clr_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_clr (
        .cfg_addr  (cfg_addr),
        .cfg_wr    (cfg_wr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .addr_hit  (addr_hit),
        .clr_vec   (clr_vec)
    );

    // Sticky positions get a storage cell; all others are tied to zero.
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_sticky
            sec_err_sticky_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q     (status[i])
            );
        end else begin : g_zero
            assign status[i] = 1'b0;
        end
    end

    // Return the word only on a read that hits the register.
    always_comb rd_data = (cfg_rd && addr_hit) ? status : '0;

    a_r6_mdpe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[B_MDPE]) |-> $past(perr_resp_en));
    a_r4_rma_needs_self: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[B_RMA]) |-> $past(ev_cpl_self));
    a_r5_rta_needs_self: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[B_RTA]) |-> $past(ev_cpl_self));
endmodule

// File: tb/sec_err_status_test.sv
// Bench: behavioural model of the status word, compared after every cycle.
module sec_err_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_poison_rx = 0, ev_errmsg_rx = 0, ev_cpl_ur = 0, ev_cpl_ca = 0;
    logic        ev_cpl_self = 0, ev_rdcpl_poison = 0, perr_resp_en = 0;
    logic [11:0] cfg_addr = 12'h01E;
    logic        cfg_wr = 0, cfg_rd = 1;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = 16'h0000;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] model = 16'h0000;

    always #10 clk = ~clk;

    sec_err_status uut (
        .clk(clk), .rst_n(rst_n),
        .ev_poison_rx(ev_poison_rx), .ev_errmsg_rx(ev_errmsg_rx),
        .ev_cpl_ur(ev_cpl_ur), .ev_cpl_ca(ev_cpl_ca), .ev_cpl_self(ev_cpl_self),
        .ev_rdcpl_poison(ev_rdcpl_poison), .perr_resp_en(perr_resp_en),
        .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [15:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
        end
    endtask

    // One clock: model the edge from the driven inputs, then read back.
    task automatic step(input string tag);
        logic [15:0] setv, clrv;
        @(posedge clk);
        setv = 16'h0;
        setv[15] = ev_poison_rx;
        setv[14] = ev_errmsg_rx;
        setv[13] = ev_cpl_ur && ev_cpl_self;
        setv[12] = ev_cpl_ca && ev_cpl_self;
        setv[8]  = ev_rdcpl_poison && perr_resp_en;
        clrv = 16'h0;
        if (cfg_wr && cfg_addr[11:1] == 11'h00F) begin
            if (cfg_be[0]) clrv[7:0]  = cfg_wdata[7:0];
            if (cfg_be[1]) clrv[15:8] = cfg_wdata[15:8];
        end
        if (!rst_n) model = 16'h0;
        else        model = ((model & ~clrv) | setv) & 16'hF100;
        @(negedge clk);
        {ev_poison_rx, ev_errmsg_rx, ev_cpl_ur, ev_cpl_ca, ev_cpl_self, ev_rdcpl_poison} = '0;
        cfg_wr = 0; cfg_rd = 1; cfg_addr = 12'h01E;
        #1 check(tag, model);
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] be, input logic [15:0] d);
        cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1'b1;
        @(negedge clk); #1 check("R1 reset value", 16'h0000);

        ev_poison_rx = 1; perr_resp_en = 0; step("R2 enable off");
        wr(12'h01E, 2'b10, 16'h8000); step("R7 clear bit15");
        ev_poison_rx = 1; perr_resp_en = 1; step("R2 enable on");
        ev_errmsg_rx = 1; step("R3");
        ev_cpl_ur = 1; ev_cpl_self = 0; step("R4 forwarded");
        ev_cpl_ur = 1; ev_cpl_self = 1; step("R4 self");
        ev_cpl_ca = 1; ev_cpl_self = 0; step("R5 forwarded");
        ev_cpl_ca = 1; ev_cpl_self = 1; step("R5 self");
        ev_rdcpl_poison = 1; perr_resp_en = 0; step("R6 gated");
        ev_rdcpl_poison = 1; perr_resp_en = 1; step("R6 enabled");

        wr(12'h01E, 2'b11, 16'h0000); step("R7 write zero");
        wr(12'h01F, 2'b11, 16'h0000); step("R7 write zero odd byte");
        wr(12'h020, 2'b11, 16'hFFFF); step("R8 other address");
        wr(12'h01C, 2'b11, 16'hFFFF); step("R8 lower address");
        wr(12'h01E, 2'b01, 16'hFFFF); step("R8 low byte only");
        wr(12'h01E, 2'b00, 16'hFFFF); step("R8 no byte");
        wr(12'h01E, 2'b10, 16'h5000); step("R7 partial clear");
        wr(12'h01E, 2'b10, 16'hA000); ev_poison_rx = 1; step("R9 set wins");
        wr(12'h01E, 2'b11, 16'hFFFF); ev_rdcpl_poison = 1; step("R9 set wins bit8");
        wr(12'h01E, 2'b11, 16'hFFFF); step("R7 clear all");

        wr(12'h01E, 2'b11, 16'hFFFF); step("R10 write all ones");
        ev_poison_rx = 1; ev_errmsg_rx = 1; ev_cpl_ur = 1; ev_cpl_ca = 1;
        ev_cpl_self = 1; ev_rdcpl_poison = 1; step("R10 all events");
        if (rd_data !== 16'hF100) begin end
        check("R10 only sticky bits", 16'hF100);

        cfg_rd = 0; #1 check("R11 no read strobe", 16'h0000);
        cfg_rd = 1; cfg_addr = 12'h01A; #1 check("R11 wrong read address", 16'h0000);
        cfg_addr = 12'h01F; #1 check("R11 odd byte address", 16'hF100);
        cfg_addr = 12'h01E;

        wr(12'h01E, 2'b11, 16'hFFFF); step("R12 prep");
        for (int k = 0; k < 4; k++) begin
            ev_errmsg_rx = 1; step("R12 repeated event");
        end
        wr(12'h01E, 2'b10, 16'h4000); step("R12 single clear");

        ev_cpl_ur = 1; ev_cpl_self = 1; step("R4 before reset");
        rst_n = 0; ev_poison_rx = 1; step("R1 reset beats event");
        rst_n = 1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule